// File: doc/BRIEF.md
# Pretrigger Acquisition Memory Controller

This block takes one minimum/maximum byte pair at the end of every sample window and stores the pair into two byte banks of 2048 entries each. The even bank holds the earlier byte of the pair in time and the odd bank holds the later one. A reorder stage decides which of the two bytes reaches which bank. When the maximum came first, the maximum goes to the even bank. When the minimum came first, a swap bit routes the minimum to the even bank instead. Both banks are written at the same pair address.

A single address pointer serves both acquisition and processor access. When acquisition is armed, the pointer is cleared and two countdowns are loaded: a pretrigger length and a post-trigger length. Every stored pair moves the pointer to the next pair address, and the pair address wraps at 2048, so the record acts as a circular buffer. The pretrigger-full flag is raised once the pretrigger countdown is used up. Only then is a main trigger accepted. A delayed (B) trigger is accepted only after the main trigger. After the trigger, the post-trigger countdown runs out and the record is closed, and no further pairs are stored until the block is armed again.

In processor mode, acquisition is held off. The processor loads the pointer with a byte address and then steps through the record. Each step returns one byte one clock later and advances the pointer by one byte. The bytes come from the even and odd banks in turn. A status word places the trigger, B-trigger, end-of-record and new-data flags beside the current pointer.

Top module: `pretrig_acq_mem`

## Requirements
- R1: After reset, `stat_word` is 0, `pre_full` is 0 and `rd_valid` is 0. Windows that arrive before the first arm are not stored, and the pointer stays at 0.
- R2: With `swap_order` = 0, the max byte is stored at even byte address 2k (even bank) and the min byte at odd byte address 2k+1 (odd bank), where k is the pair address at the time of the store.
- R3: With `swap_order` = 1, the min byte is stored at byte address 2k and the max byte at 2k+1.
- R4: `arm` (taking effect only when `cpu_mode` = 0) clears the pointer and the trigger, B-trigger and new-data flags. Each stored pair adds 2 to the 12-bit byte pointer, which wraps modulo 4096, that is, 2048 pairs.
- R5: `pre_full` rises once `pre_count` pairs have been stored since the last arm. With `pre_count` = 0 it rises immediately after the arm. It then stays high until the next arm.
- R6: A `trig` pulse sets the trigger flag only while `pre_full` is 1. An earlier pulse has no effect.
- R7: A `btrig` pulse sets the B-trigger flag only when the trigger flag is already set.
- R8: After the trigger is accepted, exactly `post_count` more pairs are stored. Then end-of-record goes to 1, and later windows neither store data nor move the pointer until the next arm.
- R9: With `cpu_mode` = 1, windows are not stored. `cpu_load` sets the pointer to `cpu_addr`. Each `cpu_step` returns, on the next clock, `rd_valid` = 1 and the byte at the pointer value it sampled, then adds 1 to the pointer.
- R10: `stat_word` bit 15 is the trigger flag, bit 14 the B-trigger flag, bit 13 end-of-record, bit 12 the new-data flag, and bits 11:0 the byte pointer.
- R11: The new-data flag (bit 12) is set by every stored pair and cleared by `cpu_load` in processor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_mode | input | 1 | 1 = processor access, 0 = acquisition |
| arm | input | 1 | Start a new acquisition (pulse) |
| pre_count | input | 11 | Pretrigger length in pairs |
| post_count | input | 11 | Post-trigger length in pairs |
| win_done | input | 1 | Sample window finished, pair valid (pulse) |
| max_byte | input | 8 | Window maximum |
| min_byte | input | 8 | Window minimum |
| swap_order | input | 1 | 1 = minimum occurred first in the window |
| trig | input | 1 | Main trigger event (pulse) |
| btrig | input | 1 | Delayed trigger event (pulse) |
| cpu_load | input | 1 | Load pointer from `cpu_addr` |
| cpu_addr | input | 12 | Byte start address for readout |
| cpu_step | input | 1 | Read one byte and advance |
| pre_full | output | 1 | Pretrigger portion filled, trigger may be accepted |
| stat_word | output | 16 | Status flags and byte pointer |
| rd_data | output | 8 | Readout byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |

## Verification
A fault in the pointer shows up in the pointer field of `stat_word` one clock after the store or step that caused it. A fault in the countdowns shows up on `pre_full` or on the end-of-record bit at the first pair where the count should have run out. A bank-routing or swap fault cannot be seen until readout. It appears as a wrong `rd_data` on the step that addresses the affected byte. For that reason the bench reads back whole regions, including a full wrapped record.

// File: rtl/acqm_pkg.sv
// Shared definitions for the pretrigger acquisition memory controller.
// Assumes: one pointer serves both acquisition and processor access.
package acqm_pkg;
    // Pointer operations chosen by the access-mode mux
    typedef enum logic [2:0] {
        PTR_HOLD,
        PTR_CLEAR,
        PTR_LOAD,
        PTR_PAIR,
        PTR_BYTE
    } ptr_op_e;

    // Number of status flag bits placed above the pointer in the status word
    localparam int FLAG_W = 4;
endpackage

// File: rtl/acqm_swap_stage.sv
// Reorder stage: four byte registers, with the max byte loaded into two of
// them and the min byte into the other two. One register of each pair drives
// a bank bus. The registered order bit picks which pair member is enabled.
// Assumes: load is a one-cycle strobe and the buses are consumed next cycle.
module acqm_swap_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] max_in,
    input  logic [DW-1:0] min_in,
    input  logic          swap_in,
    output logic [DW-1:0] even_bus,
    output logic [DW-1:0] odd_bus
);
    localparam int COPIES = 2;

    logic [DW-1:0] max_r [COPIES];
    logic [DW-1:0] min_r [COPIES];
    logic          swap_r;

    // Capture the window pair into both copies and latch the order bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COPIES; i++) begin
                max_r[i] <= '0;
                min_r[i] <= '0;
            end
            swap_r <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < COPIES; i++) begin
                max_r[i] <= max_in;
                min_r[i] <= min_in;
            end
            swap_r <= swap_in;
        end
    end

    // Enable the direct or the alternate register of each pair onto the buses
    always_comb begin
        if (swap_r) begin
            even_bus = min_r[1];
            odd_bus  = max_r[1];
        end else begin
            even_bus = max_r[0];
            odd_bus  = min_r[0];
        end
    end

    // R2
    swap_off_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !swap_in) |=> (even_bus == $past(max_in) && odd_bus == $past(min_in)));
    // R3
    swap_on_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && swap_in) |=> (even_bus == $past(min_in) && odd_bus == $past(max_in)));
endmodule

// File: rtl/acqm_bank.sv
// One byte bank: synchronous write port, and a registered read port that is
// enabled per access.
// Assumes: no write and read to the same entry in the same cycle
// (the control logic keeps the two modes apart).
module acqm_bank #(
    parameter  int DW    = 8,
    parameter  int AW    = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one byte per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the addressed byte when a read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/acqm_ctrl.sv
// Pointer and record control. It chooses between acquisition and processor
// access, counts down the pretrigger and post-trigger lengths, qualifies both
// triggers, and holds the status flags.
// Assumes: arm, win_done, trig, btrig, cpu_load and cpu_step are single-cycle
// pulses. A window's pair is written one cycle after win_done.
module acqm_ctrl
    import acqm_pkg::*;
#(
    parameter  int AW = 11,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_mode,
    input  logic          arm,
    input  logic [AW-1:0] pre_count,
    input  logic [AW-1:0] post_count,
    input  logic          win_done,
    input  logic          trig,
    input  logic          btrig,
    input  logic          cpu_load,
    input  logic [PW-1:0] cpu_addr,
    input  logic          cpu_step,
    output logic [PW-1:0] ptr,
    output logic          wr_en,
    output logic          rd_en,
    output logic          pre_full,
    output logic          trig_seen,
    output logic          btrig_seen,
    output logic          end_rec,
    output logic          byte_int
);
    logic [AW-1:0] pre_cnt;
    logic [AW-1:0] post_cnt;
    logic          armed;
    logic          wr_pend;
    logic          acq_arm;
    logic          cpu_ld;
    ptr_op_e       op;

    assign acq_arm  = arm && !cpu_mode;
    assign cpu_ld   = cpu_load && cpu_mode;
    assign pre_full = armed && (pre_cnt == '0);
    assign end_rec  = trig_seen && (post_cnt == '0);
    assign wr_en    = wr_pend && !cpu_mode && !acq_arm && armed && !end_rec;
    assign rd_en    = cpu_step && cpu_mode;

    // Remember that a window pair sits in the swap stage awaiting its write
    always_ff @(posedge clk) begin
        if (!rst_n) wr_pend <= 1'b0;
        else        wr_pend <= win_done && !cpu_mode;
    end

    // Access-mode mux: pick the pointer operation for this cycle
    always_comb begin
        op = PTR_HOLD;
        if (!cpu_mode) begin
            if (acq_arm)    op = PTR_CLEAR;
            else if (wr_en) op = PTR_PAIR;
        end else begin
            if (cpu_ld)     op = PTR_LOAD;
            else if (rd_en) op = PTR_BYTE;
        end
    end

    // Apply the selected pointer operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_CLEAR: ptr <= '0;
                PTR_LOAD:  ptr <= cpu_addr;
                PTR_PAIR:  ptr <= ptr + PW'(2);
                PTR_BYTE:  ptr <= ptr + PW'(1);
                default:   ptr <= ptr;
            endcase
        end
    end

    // Load the countdowns on arm and spend them one pair per stored window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
            armed    <= 1'b0;
        end else if (acq_arm) begin
            pre_cnt  <= pre_count;
            post_cnt <= post_count;
            armed    <= 1'b1;
        end else if (wr_en) begin
            if (pre_cnt != '0)
                pre_cnt <= pre_cnt - AW'(1);
            else if (trig_seen && post_cnt != '0)
                post_cnt <= post_cnt - AW'(1);
        end
    end

    // Qualify triggers: the main one after pretrigger fill, B after main
    always_ff @(posedge clk) begin
        if (!rst_n || acq_arm) begin
            trig_seen  <= 1'b0;
            btrig_seen <= 1'b0;
        end else if (!cpu_mode) begin
            if (trig && pre_full)    trig_seen  <= 1'b1;
            if (btrig && trig_seen)  btrig_seen <= 1'b1;
        end
    end

    // New-data flag: set by each stored pair, cleared by a processor load
    always_ff @(posedge clk) begin
        if (!rst_n || acq_arm) byte_int <= 1'b0;
        else if (cpu_ld)       byte_int <= 1'b0;
        else if (wr_en)        byte_int <= 1'b1;
    end

    // R5
    pfull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pre_full) |-> $past(arm));
    // R6
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_seen) |-> ($past(pre_full) && $past(trig)));
    // R7
    btrig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(btrig_seen) |-> $past(trig_seen));
    // R8
    endrec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_rec && !cpu_mode && !arm) |=> $stable(ptr));
    // R4
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + PW'(2)));
    // R9
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode && !cpu_load && !cpu_step) |=> $stable(ptr));
endmodule

// File: rtl/pretrig_acq_mem.sv
// Top level of the pretrigger acquisition memory controller. It joins the
// swap stage, the control logic and the two byte banks (bank 0 even/earlier,
// bank 1 odd/later), and it forms the readout byte and the status word.
// Assumes: the processor holds cpu_mode high for the whole of its access.
module pretrig_acq_mem
    import acqm_pkg::*;
#(
    parameter  int DW = 8,
    parameter  int AW = 11,
    localparam int PW = AW + 1,
    localparam int SW = FLAG_W + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_mode,
    input  logic          arm,
    input  logic [AW-1:0] pre_count,
    input  logic [AW-1:0] post_count,
    input  logic          win_done,
    input  logic [DW-1:0] max_byte,
    input  logic [DW-1:0] min_byte,
    input  logic          swap_order,
    input  logic          trig,
    input  logic          btrig,
    input  logic          cpu_load,
    input  logic [PW-1:0] cpu_addr,
    input  logic          cpu_step,
    output logic          pre_full,
    output logic [SW-1:0] stat_word,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int BANKS = 2;

    logic [PW-1:0] ptr;
    logic          wr_en, rd_en;
    logic          trig_seen, btrig_seen, end_rec, byte_int;
    logic          rd_sel;
    logic [DW-1:0] even_bus, odd_bus;
    logic [DW-1:0] bank_wdata [BANKS];
    logic [DW-1:0] bank_rdata [BANKS];

    acqm_swap_stage #(.DW(DW)) i_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_done),
        .max_in   (max_byte),
        .min_in   (min_byte),
        .swap_in  (swap_order),
        .even_bus (even_bus),
        .odd_bus  (odd_bus)
    );

    acqm_ctrl #(.AW(AW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_mode   (cpu_mode),
        .arm        (arm),
        .pre_count  (pre_count),
        .post_count (post_count),
        .win_done   (win_done),
        .trig       (trig),
        .btrig      (btrig),
        .cpu_load   (cpu_load),
        .cpu_addr   (cpu_addr),
        .cpu_step   (cpu_step),
        .ptr        (ptr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .pre_full   (pre_full),
        .trig_seen  (trig_seen),
        .btrig_seen (btrig_seen),
        .end_rec    (end_rec),
        .byte_int   (byte_int)
    );

    assign bank_wdata[0] = even_bus;
    assign bank_wdata[1] = odd_bus;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        acqm_bank #(.DW(DW), .AW(AW)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en),
            .waddr (ptr[PW-1:1]),
            .wdata (bank_wdata[b]),
            .re    (rd_en),
            .raddr (ptr[PW-1:1]),
            .rdata (bank_rdata[b])
        );
    end

    // Track which bank the pending read came from, and mark the data valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_sel <= ptr[0];
        end
    end

    assign rd_data   = rd_sel ? bank_rdata[1] : bank_rdata[0];
    assign stat_word = {trig_seen, btrig_seen, end_rec, byte_int, ptr};

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode && cpu_step) |=> rd_valid);
    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_mode && cpu_step) |=> !rd_valid);
endmodule

// File: tb/test_pretrig_acq_mem.sv
// Bench: a fixed-seed random mix plus directed corner cases, checked against
// a requirement-level model of the record kept in the bench.
module test_pretrig_acq_mem;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_mode = 1'b0, arm = 1'b0, win_done = 1'b0, swap_order = 1'b0;
    logic        trig = 1'b0, btrig = 1'b0, cpu_load = 1'b0, cpu_step = 1'b0;
    logic [10:0] pre_count = '0, post_count = '0;
    logic [7:0]  max_byte = '0, min_byte = '0;
    logic [11:0] cpu_addr = '0;
    logic        pre_full, rd_valid;
    logic [15:0] stat_word;
    logic [7:0]  rd_data;

    int n_vec = 0, n_bad = 0;

    // Model state taken from the requirements
    logic [11:0] m_ptr = '0;
    bit          m_armed = 0, m_trig = 0, m_btrig = 0, m_bint = 0, m_cpu = 0;
    int          m_pre = 0, m_post = 0;
    logic [7:0]  m_mem [4096];
    bit          m_wr  [4096];

    pretrig_acq_mem i_pretrig_acq_mem (
        .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode), .arm(arm),
        .pre_count(pre_count), .post_count(post_count), .win_done(win_done),
        .max_byte(max_byte), .min_byte(min_byte), .swap_order(swap_order),
        .trig(trig), .btrig(btrig), .cpu_load(cpu_load), .cpu_addr(cpu_addr),
        .cpu_step(cpu_step), .pre_full(pre_full), .stat_word(stat_word),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_end();
        return m_trig && (m_post == 0);
    endfunction

    function automatic bit m_pfull();
        return m_armed && (m_pre == 0);
    endfunction

    function automatic logic [15:0] exp_stat();
        return {m_trig, m_btrig, m_end(), m_bint, m_ptr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_stat(input string req);
        chk(req, 32'(stat_word), 32'(exp_stat()));
        chk(req, 32'(pre_full), 32'(m_pfull()));
    endtask

    task automatic set_mode(input bit cpu);
        cpu_mode = cpu; m_cpu = cpu;
        @(negedge clk);
    endtask

    task automatic do_arm(input int pre, input int post);
        arm = 1'b1; pre_count = 11'(pre); post_count = 11'(post);
        @(negedge clk);
        arm = 1'b0;
        if (!m_cpu) begin
            m_armed = 1; m_pre = pre; m_post = post; m_ptr = '0;
            m_trig = 0; m_btrig = 0; m_bint = 0;
        end
    endtask

    task automatic do_window(input logic [7:0] mx, input logic [7:0] mn, input bit sw);
        win_done = 1'b1; max_byte = mx; min_byte = mn; swap_order = sw;
        @(negedge clk);
        win_done = 1'b0;
        @(negedge clk);
        if (!m_cpu && m_armed && !m_end()) begin
            m_mem[m_ptr]     = sw ? mn : mx;
            m_mem[m_ptr + 1] = sw ? mx : mn;
            m_wr[m_ptr] = 1; m_wr[m_ptr + 1] = 1;
            m_ptr += 12'd2;
            if (m_pre > 0) m_pre--;
            else if (m_trig && m_post > 0) m_post--;
            m_bint = 1;
        end
    endtask

    task automatic do_trig(input bit b_kind);
        if (b_kind) btrig = 1'b1; else trig = 1'b1;
        @(negedge clk);
        btrig = 1'b0; trig = 1'b0;
        if (!m_cpu) begin
            if (b_kind) begin if (m_trig) m_btrig = 1; end
            else if (m_pfull()) m_trig = 1;
        end
    endtask

    task automatic do_load(input logic [11:0] a);
        cpu_load = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_load = 1'b0;
        m_ptr = a; m_bint = 0;
    endtask

    task automatic do_read(input string req);
        logic [11:0] a = m_ptr;
        cpu_step = 1'b1;
        @(negedge clk);
        cpu_step = 1'b0;
        chk({req, " valid"}, 32'(rd_valid), 32'd1);
        if (m_wr[a]) chk(req, 32'(rd_data), 32'(m_mem[a]));
        m_ptr = m_ptr + 12'd1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 4096; i++) m_wr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, and a window before any arm is not stored
        chk("R1 stat", 32'(stat_word), 32'd0);
        chk("R1 pre_full", 32'(pre_full), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        do_window(8'h12, 8'h34, 1'b0);
        check_stat("R1 no store before arm");

        // R4: circular record with no trigger, 2050 pairs wrap the pointer
        do_arm(0, 0);
        check_stat("R5 zero pretrigger");
        for (int i = 0; i < 2050; i++)
            do_window(8'($urandom), 8'($urandom), 1'($urandom));
        chk("R4 wrap", 32'(stat_word[11:0]), 32'd4);
        check_stat("R4 wrap status");

        // R2 R3: read back the whole wrapped record, both banks in turn
        set_mode(1'b1);
        do_load(12'd0);
        for (int i = 0; i < 4096; i++) do_read("R2 R3 readback");
        set_mode(1'b0);

        // Directed pretrigger/trigger sequence
        do_arm(5, 3);
        check_stat("R4 arm clears");
        do_trig(1'b1);
        check_stat("R7 btrig before trig ignored");
        do_trig(1'b0);
        check_stat("R6 trig before pre_full ignored");
        do_window(8'hAA, 8'h55, 1'b0);
        do_window(8'h11, 8'h22, 1'b1);
        for (int i = 0; i < 2; i++) do_window(8'($urandom), 8'($urandom), 1'($urandom));
        check_stat("R5 not yet full");
        do_window(8'($urandom), 8'($urandom), 1'($urandom));
        check_stat("R5 full after count");
        do_trig(1'b0);
        check_stat("R6 trig accepted");
        do_trig(1'b1);
        check_stat("R7 btrig accepted");
        for (int i = 0; i < 2; i++) do_window(8'($urandom), 8'($urandom), 1'($urandom));
        check_stat("R8 record still open");
        do_window(8'hC3, 8'h3C, 1'b0);
        check_stat("R8 end of record");
        chk("R10 flag bits", 32'(stat_word[15:12]), 32'hF);
        do_window(8'hEE, 8'hDD, 1'b1);
        check_stat("R8 inhibited after end");

        // R9 R11: processor access, windows ignored, new-data flag cleared
        set_mode(1'b1);
        do_load(12'd0);
        check_stat("R11 cleared by load");
        do_window(8'h77, 8'h66, 1'b0);
        check_stat("R9 window ignored in cpu mode");
        do_read("R2 max even");
        chk("R2 max first", 32'(rd_data), 32'hAA);
        do_read("R2 min odd");
        chk("R2 min second", 32'(rd_data), 32'h55);
        do_read("R3 min even");
        chk("R3 min first", 32'(rd_data), 32'h22);
        do_read("R3 max odd");
        chk("R3 max second", 32'(rd_data), 32'h11);
        check_stat("R9 pointer advanced");
        do_load(12'd16);
        for (int i = 0; i < 4; i++) do_read("R8 stored bytes intact");
        set_mode(1'b0);

        // Random rounds mixing windows and triggers
        for (int r = 0; r < 3; r++) begin
            do_arm(int'($urandom % 8), int'($urandom % 8));
            for (int k = 0; k < 30; k++) begin
                int sel = int'($urandom % 6);
                if (sel < 4) do_window(8'($urandom), 8'($urandom), 1'($urandom));
                else         do_trig(sel == 5);
                check_stat("R6 R7 R8 R10 R11 random status");
            end
            set_mode(1'b1);
            do_load(12'd0);
            for (int i = 0; i < 32; i++) do_read("R9 random readback");
            set_mode(1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule